// File: doc/BRIEF.md
# CAN Transmit Mailbox Control and Status Register

This block keeps the control and status byte of a single CAN transmit mailbox. Software reads and writes the byte through an 8-bit register port. Two bits in the byte carry software commands: a transmit request and an abort request. The other bits report what the protocol engine did with the last request. The protocol engine reports each finished transmission attempt, with its outcome, and each finished abort. The block uses these reports to update the byte and to withdraw its requests to the engine.

Two outputs copy the request-completed and transmit-OK bits for a chip-level transmit status register. A mailbox-empty flag gates writes to the mailbox's message registers. A build parameter selects a receive-side configuration, in which those message registers never accept a write.

Top module: `txmb_ctrl_status`

## Requirements
- R1: After a synchronous reset, the register reads 0x00. The mailbox-empty flag is 1, and the request, abort and both mirror outputs are 0. Bits 7 and 6 always read 0.
- R2: The read layout is fixed:
  - bit 0: transmit request
  - bit 1: abort request
  - bit 2: request completed
  - bit 3: transmit OK
  - bit 4: arbitration lost
  - bit 5: transmission error

  Software writes to bits 7 to 3 have no effect.
- R3: Writing 1 to bit 0 sets the transmit request. Writing 0 to it has no effect. The mailbox-empty flag equals the inverse of bit 0. A successful attempt or a completed abort clears bit 0, and this clear wins over a set written in the same cycle.
- R4: An attempt-done report counts only while bit 0 is set. It then loads the status bits as follows:
  - transmit OK = success
  - arbitration lost = lost AND NOT success
  - error = error AND NOT success AND NOT lost

  A failed attempt leaves bit 0 set and does not change bit 2.
- R5: Bit 2 is set by a successful attempt or by a completed abort. An abort is complete when the engine's abort-done report arrives while both bit 1 and bit 0 are set, and no success arrives in the same cycle. A completed abort clears bits 0 and 1 and keeps bits 5 to 3.
- R6: Writing 1 to bit 2 clears bits 2, 3, 4 and 5. Writing 0 to bit 2 has no effect.
- R7: Setting bit 0 while it is clear also clears bits 2 to 5 in the same update.
- R8: If an attempt report or a completion event happens in the same cycle as a software clear of bit 2, the hardware update wins and the software clear is ignored.
- R9: Writing 1 to bit 1 sets the abort request only if bit 0 is set or is being set by the same write.
  - Otherwise that write completes at once: bit 2 is set, bit 3 is cleared, bits 4 and 5 are kept, and bit 1 stays 0.
  - Bit 1 is cleared whenever bit 0 is cleared by hardware.
- R10: The two mirror outputs always equal bit 2 and bit 3 of the register.
- R11: A message-register write is granted only when it is requested and bit 0 is clear. With the receive configuration, it is never granted.
- R12: Engine reports have no effect in these cases:
  - an attempt-done report while no transmission is pending;
  - an abort-done report while no abort is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 8 | Register write data |
| csr_rd_data | output | 8 | Current register value |
| eng_attempt_done | input | 1 | Engine finished a transmission attempt |
| eng_tx_ok | input | 1 | Outcome of the attempt: success |
| eng_arb_lost | input | 1 | Outcome of the attempt: arbitration lost |
| eng_tx_err | input | 1 | Outcome of the attempt: bus error |
| eng_abort_done | input | 1 | Engine finished an abort |
| msg_wr_req | input | 1 | Write request toward the message registers |
| msg_wr_grant | output | 1 | Message register write permitted |
| tx_request | output | 1 | Transmit request to the engine |
| abort_request | output | 1 | Abort request to the engine |
| mbox_empty | output | 1 | Mailbox holds no pending transmission |
| gsr_req_done | output | 1 | Mirror of request completed |
| gsr_tx_ok | output | 1 | Mirror of transmit OK |

## Verification
The bench builds the block twice, once with the receive configuration off and once with it on. It drives both instances with the same stimulus, so the permanent write lock of the receive build is checked in every cycle.

The transmit build is first placed in one of five starting states: empty, pending, pending with abort, completed with success, and pending after a lost arbitration. From each of these states the bench applies:
- every one of the 256 write values, and
- every combination of the five engine report lines, each paired with several command writes.

This sweep reaches every collision of a software command with an engine report, including a clear racing a completion and an abort issued while the mailbox is empty.

// File: rtl/txmb_pkg.sv
package txmb_pkg;

    localparam int CSR_W  = 8;
    localparam int B_TXRQ = 0;
    localparam int B_ABRQ = 1;
    localparam int B_RQCP = 2;
    localparam int B_TXOK = 3;
    localparam int B_ALST = 4;
    localparam int B_TERR = 5;

    typedef struct packed {
        logic done;
        logic ok;
        logic arb;
        logic err;
        logic abort_done;
    } eng_evt_t;

    typedef struct packed {
        logic terr;
        logic alst;
        logic txok;
    } att_res_t;

    typedef struct packed {
        logic attempt;
        logic tx_done;
        logic abort_done;
        logic idle_abort;
        logic new_req;
    } hw_evt_t;

    typedef struct packed {
        logic set_tx;
        logic set_ab;
        logic clr_rq;
    } sw_cmd_t;

    function automatic att_res_t classify(eng_evt_t e);
        att_res_t r;
        r.txok = e.ok;
        r.alst = e.arb & ~e.ok;
        r.terr = e.err & ~e.ok & ~e.arb;
        return r;
    endfunction

    function automatic sw_cmd_t decode_wr(logic wr, logic [2:0] d);
        sw_cmd_t c;
        c.set_tx = wr & d[B_TXRQ];
        c.set_ab = wr & d[B_ABRQ];
        c.clr_rq = wr & d[B_RQCP];
        return c;
    endfunction

    function automatic logic [CSR_W-1:0] pack_csr(logic txrq, logic abrq,
                                                  logic rqcp, att_res_t s);
        logic [CSR_W-1:0] v;
        v         = '0;
        v[B_TXRQ] = txrq;
        v[B_ABRQ] = abrq;
        v[B_RQCP] = rqcp;
        v[B_TXOK] = s.txok;
        v[B_ALST] = s.alst;
        v[B_TERR] = s.terr;
        return v;
    endfunction

endpackage

// File: rtl/txmb_req_ctrl.sv
module txmb_req_ctrl
    import txmb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sw_cmd_t  cmd,
    input  eng_evt_t eng,
    output logic     txrq_q,
    output logic     abrq_q,
    output hw_evt_t  hw
);

    always_comb begin
        hw.attempt    = eng.done & txrq_q;
        hw.tx_done    = eng.done & txrq_q & eng.ok;
        hw.abort_done = eng.abort_done & abrq_q & txrq_q & ~(eng.done & eng.ok);
        hw.idle_abort = cmd.set_ab & ~txrq_q & ~cmd.set_tx;
        hw.new_req    = cmd.set_tx & ~txrq_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txrq_q <= 1'b0;
            abrq_q <= 1'b0;
        end else if (hw.tx_done || hw.abort_done) begin
            txrq_q <= 1'b0;
            abrq_q <= 1'b0;
        end else begin
            if (cmd.set_tx)
                txrq_q <= 1'b1;
            if (cmd.set_ab && (txrq_q || cmd.set_tx))
                abrq_q <= 1'b1;
        end
    end

    // R9: a pending abort always has a pending transmission
    p_abort_needs_tx_r9: assert property (@(posedge clk) disable iff (rst)
        abrq_q |-> txrq_q);

    // R3: a successful attempt withdraws the request
    p_success_clears_r3: assert property (@(posedge clk) disable iff (rst)
        hw.tx_done |=> !txrq_q && !abrq_q);

    // R12: an attempt report with nothing pending changes nothing
    p_idle_report_r12: assert property (@(posedge clk) disable iff (rst)
        (!txrq_q && !cmd.set_tx) |=> !txrq_q);

endmodule

// File: rtl/txmb_result.sv
module txmb_result
    import txmb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_rq,
    input  hw_evt_t  hw,
    input  att_res_t res_in,
    output logic     rqcp_q,
    output att_res_t stat_q
);

    logic hw_any;
    logic completion;

    always_comb begin
        completion = hw.tx_done | hw.abort_done | hw.idle_abort;
        hw_any     = completion | hw.attempt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rqcp_q <= 1'b0;
            stat_q <= '0;
        end else if (hw_any) begin
            if (completion)
                rqcp_q <= 1'b1;
            if (hw.attempt)
                stat_q <= res_in;
            else if (hw.idle_abort)
                stat_q.txok <= 1'b0;
        end else if (clr_rq || hw.new_req) begin
            rqcp_q <= 1'b0;
            stat_q <= '0;
        end
    end

    // R6: a software clear with no competing event wipes all result flags
    p_sw_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_rq && !hw_any) |=> !rqcp_q && stat_q == '0);

    // R8: completion wins over a same-cycle clear
    p_hw_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (completion && clr_rq) |=> rqcp_q);

    // R7: a fresh request starts with clean results
    p_new_req_r7: assert property (@(posedge clk) disable iff (rst)
        hw.new_req |=> !rqcp_q && !stat_q.txok);

    // R9: an abort issued while empty never reports success
    p_idle_abort_r9: assert property (@(posedge clk) disable iff (rst)
        hw.idle_abort |=> rqcp_q && !stat_q.txok);

endmodule

// File: rtl/txmb_msg_gate.sv
module txmb_msg_gate #(
    parameter bit RX_CFG = 1'b0
) (
    input  logic req,
    input  logic busy,
    output logic grant
);

    generate
        if (RX_CFG) begin : g_rx
            assign grant = 1'b0;
        end else begin : g_tx
            assign grant = req & ~busy;
        end
    endgenerate

endmodule

// File: rtl/txmb_ctrl_status.sv
module txmb_ctrl_status
    import txmb_pkg::*;
#(
    parameter bit RX_CFG = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr_en,
    input  logic [CSR_W-1:0] csr_wr_data,
    output logic [CSR_W-1:0] csr_rd_data,
    input  logic             eng_attempt_done,
    input  logic             eng_tx_ok,
    input  logic             eng_arb_lost,
    input  logic             eng_tx_err,
    input  logic             eng_abort_done,
    input  logic             msg_wr_req,
    output logic             msg_wr_grant,
    output logic             tx_request,
    output logic             abort_request,
    output logic             mbox_empty,
    output logic             gsr_req_done,
    output logic             gsr_tx_ok
);

    sw_cmd_t  cmd;
    eng_evt_t eng;
    hw_evt_t  hw;
    att_res_t res_in;
    att_res_t stat;
    logic     txrq;
    logic     abrq;
    logic     rqcp;
    logic     unused_wr_hi;

    always_comb begin
        cmd            = decode_wr(csr_wr_en, csr_wr_data[2:0]);
        eng.done       = eng_attempt_done;
        eng.ok         = eng_tx_ok;
        eng.arb        = eng_arb_lost;
        eng.err        = eng_tx_err;
        eng.abort_done = eng_abort_done;
        res_in         = classify(eng);
        unused_wr_hi   = ^csr_wr_data[CSR_W-1:3];
    end

    txmb_req_ctrl u_req (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .eng    (eng),
        .txrq_q (txrq),
        .abrq_q (abrq),
        .hw     (hw)
    );

    txmb_result u_res (
        .clk    (clk),
        .rst    (rst),
        .clr_rq (cmd.clr_rq),
        .hw     (hw),
        .res_in (res_in),
        .rqcp_q (rqcp),
        .stat_q (stat)
    );

    txmb_msg_gate #(.RX_CFG(RX_CFG)) u_gate (
        .req   (msg_wr_req),
        .busy  (txrq),
        .grant (msg_wr_grant)
    );

    always_comb begin
        csr_rd_data   = pack_csr(txrq, abrq, rqcp, stat);
        tx_request    = txrq;
        abort_request = abrq;
        mbox_empty    = ~txrq;
        gsr_req_done  = rqcp;
        gsr_tx_ok     = stat.txok;
    end

    // R1: first cycle out of reset shows the cleared register
    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> csr_rd_data == '0 && mbox_empty);

    // R11: no message write is granted while a transmission is pending
    p_gate_busy_r11: assert property (@(posedge clk) disable iff (rst)
        msg_wr_grant |-> !tx_request);

    // R2: status bits do not move on a write with no engine report
    p_status_ro_r2: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && !csr_wr_data[B_RQCP] && !csr_wr_data[B_TXRQ] &&
         !csr_wr_data[B_ABRQ] && !eng_attempt_done && !eng_abort_done)
        |=> $stable(csr_rd_data[B_TERR:B_TXOK]));

endmodule

// File: tb/txmb_ctrl_status_test.sv
`timescale 1ns/1ps
module txmb_ctrl_status_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       e_done = 1'b0, e_ok = 1'b0, e_arb = 1'b0, e_err = 1'b0, e_abd = 1'b0;
    logic       m_req = 1'b0;
    logic [7:0] rd, rd_rx;
    logic       grant, grant_rx, txr, abr, empty, g_rq, g_ok;
    logic       txr_rx, abr_rx, empty_rx, g_rq_rx, g_ok_rx;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    // model state
    logic m_tx, m_ab, m_rq, m_ok, m_al, m_er;

    always #2 clk = ~clk;

    txmb_ctrl_status #(.RX_CFG(1'b0)) uut (
        .clk(clk), .rst(rst), .csr_wr_en(wr_en), .csr_wr_data(wr_data),
        .csr_rd_data(rd), .eng_attempt_done(e_done), .eng_tx_ok(e_ok),
        .eng_arb_lost(e_arb), .eng_tx_err(e_err), .eng_abort_done(e_abd),
        .msg_wr_req(m_req), .msg_wr_grant(grant), .tx_request(txr),
        .abort_request(abr), .mbox_empty(empty), .gsr_req_done(g_rq),
        .gsr_tx_ok(g_ok));

    txmb_ctrl_status #(.RX_CFG(1'b1)) uut_rx (
        .clk(clk), .rst(rst), .csr_wr_en(wr_en), .csr_wr_data(wr_data),
        .csr_rd_data(rd_rx), .eng_attempt_done(e_done), .eng_tx_ok(e_ok),
        .eng_arb_lost(e_arb), .eng_tx_err(e_err), .eng_abort_done(e_abd),
        .msg_wr_req(m_req), .msg_wr_grant(grant_rx), .tx_request(txr_rx),
        .abort_request(abr_rx), .mbox_empty(empty_rx), .gsr_req_done(g_rq_rx),
        .gsr_tx_ok(g_ok_rx));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_csr();
        return {2'b00, m_er, m_al, m_ok, m_rq, m_ab, m_tx};
    endfunction

    // expected next state, written from the requirements
    task automatic model_step(input logic wr, input logic [7:0] v,
                              input logic d, input logic ok, input logic arb,
                              input logic err, input logic abd);
        logic s_tx, s_ab, c_rq, att, txd, ab_c, ia, nr, comp;
        s_tx = wr & v[0];
        s_ab = wr & v[1];
        c_rq = wr & v[2];
        att  = d & m_tx;                       // R4, R12
        txd  = att & ok;                       // R3, R5
        ab_c = abd & m_ab & m_tx & ~txd;       // R5, R12
        ia   = s_ab & ~m_tx & ~s_tx;           // R9
        nr   = s_tx & ~m_tx;                   // R7
        comp = txd | ab_c | ia;
        if (att | comp) begin                  // R8: hardware wins
            if (comp) m_rq = 1'b1;
            if (att) begin
                m_ok = ok;
                m_al = arb & ~ok;
                m_er = err & ~ok & ~arb;
            end else if (ia) begin
                m_ok = 1'b0;
            end
        end else if (c_rq | nr) begin          // R6, R7
            m_rq = 1'b0; m_ok = 1'b0; m_al = 1'b0; m_er = 1'b0;
        end
        if (txd | ab_c) begin
            m_tx = 1'b0; m_ab = 1'b0;
        end else begin
            if (s_ab && (m_tx || s_tx)) m_ab = 1'b1;
            if (s_tx) m_tx = 1'b1;
        end
    endtask

    task automatic check_all();
        chk("R2 reserved bits", {6'b0, rd[7:6]}, 8'h00);
        chk("R3 request bit", {7'b0, rd[0]}, {7'b0, m_tx});
        chk("R3 empty flag", {7'b0, empty}, {7'b0, ~m_tx});
        chk("R9 abort bit", {6'b0, rd[1], abr}, {6'b0, m_ab, m_ab});
        chk("R5 completed bit", {7'b0, rd[2]}, {7'b0, m_rq});
        chk("R4 status bits", {5'b0, rd[5:3]}, {5'b0, m_er, m_al, m_ok});
        chk("R10 mirrors", {6'b0, g_rq, g_ok}, {6'b0, m_rq, m_ok});
        chk("R11 grant", {6'b0, grant, grant_rx}, {6'b0, m_req & ~m_tx, 1'b0});
    endtask

    task automatic apply(input logic [7:0] v, input logic wr, input logic [4:0] ev);
        wr_en = wr; wr_data = v;
        {e_done, e_ok, e_arb, e_err, e_abd} = ev;
        model_step(wr, v, ev[4], ev[3], ev[2], ev[1], ev[0]);
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = 8'h00;
        {e_done, e_ok, e_arb, e_err, e_abd} = 5'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        {m_tx, m_ab, m_rq, m_ok, m_al, m_er} = 6'b0;
    endtask

    task automatic prep(input int p);
        do_reset();
        case (p)
            1: apply(8'h01, 1'b1, 5'b0);
            2: apply(8'h03, 1'b1, 5'b0);
            3: begin apply(8'h01, 1'b1, 5'b0); apply(8'h00, 1'b0, 5'b11000); end
            4: begin apply(8'h01, 1'b1, 5'b0); apply(8'h00, 1'b0, 5'b10100); end
            default: ;
        endcase
    endtask

    initial begin
        #(4 * 200000);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 reset value", rd, 8'h00);
        chk("R1 reset outputs", {3'b0, empty, txr, abr, g_rq, g_ok}, 8'h10);

        // directed corners
        prep(3); apply(8'h04, 1'b1, 5'b0);
        chk("R6 clear wipes results", rd, 8'h00);
        prep(3); apply(8'h01, 1'b1, 5'b0);
        chk("R7 new request clears results", rd, 8'h01);
        prep(4); apply(8'h04, 1'b1, 5'b11000);
        chk("R8 completion beats clear", rd, 8'h0C);
        prep(0); apply(8'h00, 1'b0, 5'b11111);
        chk("R12 idle reports ignored", rd, 8'h00);
        prep(1); apply(8'h00, 1'b0, 5'b00001);
        chk("R12 abort-done without abort", rd, 8'h01);
        prep(0); apply(8'h02, 1'b1, 5'b0);
        chk("R9 idle abort completes", rd, 8'h04);
        prep(2); apply(8'h00, 1'b0, 5'b00001);
        chk("R5 abort completion", rd, 8'h04);
        prep(4); apply(8'hF8, 1'b1, 5'b0);
        chk("R2 read-only bits kept", rd, 8'h11);

        // sweep all write values from each start state
        for (int p = 0; p < 5; p++) begin
            for (int v = 0; v < 256; v++) begin
                prep(p);
                m_req = v[7];
                apply(v[7:0], 1'b1, 5'b0);
                check_all();
            end
        end

        // sweep all engine report combinations with a set of writes
        for (int p = 0; p < 5; p++) begin
            for (int ev = 0; ev < 32; ev++) begin
                for (int w = 0; w < 5; w++) begin
                    logic [7:0] wv;
                    case (w)
                        0: wv = 8'h00;
                        1: wv = 8'h01;
                        2: wv = 8'h02;
                        3: wv = 8'h04;
                        default: wv = 8'h07;
                    endcase
                    prep(p);
                    m_req = ev[0];
                    apply(wv, w != 0, ev[4:0]);
                    check_all();
                end
            end
        end

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule